// File: doc/BRIEF.md
# Coprocessor Escape Instruction Snooper

This block sits beside a host processor on a shared bus and follows the host's instruction stream without being told which instructions are its own. Code bytes that the host fetches are copied into a local shadow queue. The host's 2-bit queue-status lines then say when a byte leaves the host's own queue. The block pops its copy at the same moment, so it decodes instructions in execution order and not in fetch order.

When a dequeued first byte carries the escape prefix, the block collects the addressing byte and any displacement bytes. It then publishes the 6-bit opcode, the addressing fields and an operand-length code. A register-form instruction completes at once. A memory-form instruction waits for the host's dummy data read, keeps only the address of that read, and may then request bus mastership to move the rest of the operand, or the whole of it for a store. The width of the host data bus is learned from the data bus while reset is held. That width sets the queue capacity and the size of each transfer.

Top module: `esc_snooper`

## Requirements
- R1: While `rst_n` is low, `host_wide` takes the value of `bus_data[0]` (1 = 16-bit host, 0 = 8-bit host), and it keeps that value after reset is released.
- R2: `qstat` encodings are 00 idle, 01 first byte dequeued, 10 flush, 11 next byte dequeued. Decoding uses bytes in dequeue order, so bytes fetched early wait in the queue until they are dequeued.
- R3: Decoding starts only when a byte dequeued with status 01 has bits [7:3] = 11011. Any other first byte produces no `dec_valid`.
- R4: `dec_op` = {first byte [2:0], second byte [5:3]}, `dec_mode` = second byte [7:6], `dec_rm` = second byte [2:0], and `dec_len` = first byte [2:1]. The length code gives the operand size: 0 = 2 bytes, 1 = 4 bytes, 2 = 8 bytes, 3 = 10 bytes.
- R5: Mode 01 consumes one displacement byte and mode 10 consumes two, each with status 11, before the instruction completes. Mode 00 consumes none.
- R6: Mode 11 (register operand) gives `dec_valid` with `dec_addr` = 0 and makes no bus request.
- R7: A memory-form instruction waits for a completed data read (`bus_done`=1, `bus_is_code`=0). It captures `bus_addr` as `dec_addr` and pulses `dec_valid` for one cycle. The read data and any code fetches have no effect on this.
- R8: For a load (second byte bit 5 = 0), the operand is split into beats of 2 bytes (16-bit host) or 1 byte (8-bit host). The block reads the beats after the first, at consecutive beat addresses starting one beat above the captured address. It makes no request if only one beat exists.
- R9: For a store (second byte bit 5 = 1), the block writes every beat of the operand (`xfer_we`=1), starting at the captured address.
- R10: `xfer_en` is high only while both `bus_req` and `bus_gnt` are high, and `bus_req` falls in the cycle right after the last transfer.
- R11: Status 10 empties the shadow queue and abandons any partly decoded instruction.
- R12: A completed code fetch (`bus_done`=1, `bus_is_code`=1) enqueues `bus_data[7:0]` then `bus_data[15:8]` on a 16-bit host, or only `bus_data[7:0]` on an 8-bit host. The fetch is dropped if the bytes would not fit in 6 entries (16-bit host) or 4 entries (8-bit host).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qstat | input | 2 | Host queue status |
| bus_done | input | 1 | A host bus cycle completes this clock |
| bus_is_code | input | 1 | The completing cycle is a code fetch |
| bus_addr | input | AW | Address of the completing cycle |
| bus_data | input | 16 | Data bus; also senses host width during reset |
| bus_gnt | input | 1 | Bus mastership granted |
| host_wide | output | 1 | Detected host width, 1 = 16-bit |
| bus_req | output | 1 | Bus mastership request |
| xfer_en | output | 1 | Own transfer performed this cycle |
| xfer_we | output | 1 | Transfer direction, 1 = write |
| xfer_addr | output | AW | Transfer address |
| dec_valid | output | 1 | Decoded-instruction pulse |
| dec_op | output | 6 | Coprocessor opcode |
| dec_mode | output | 2 | Mode field |
| dec_rm | output | 3 | Register/memory field |
| dec_len | output | 2 | Operand length code |
| dec_addr | output | AW | Captured operand address (0 for register form) |

## Verification
The bench uses the default parameters: a 20-bit address, 6 queue entries for a 16-bit host and 4 for an 8-bit host. It resets the block twice, once with each sensed width, so both capacities and both beat sizes are exercised. With 6 and 4 entries, three or two short instructions fill the queue, which makes the dropped-fetch case easy to provoke. The length codes used give one-beat loads with no request and multi-beat loads and stores under both widths.

// File: rtl/esc_snoop_pkg.sv
// Shared encodings and helpers for the escape-instruction snooper.
package esc_snoop_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    localparam logic [4:0] ESC_PREFIX = 5'b11011;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] mode;
        logic [2:0] rm;
        logic [1:0] len;
        logic       store;
    } ins_t;

    // Operand size in bytes for a length code.
    function automatic logic [3:0] len_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            2'd2:    return 4'd8;
            default: return 4'd10;
        endcase
    endfunction

    // Number of bus beats needed for an operand at the given host width.
    function automatic logic [3:0] beat_count(input logic [1:0] code, input logic wide);
        logic [3:0] b;
        b = len_bytes(code);
        return wide ? (b >> 1) : b;
    endfunction

endpackage

// File: rtl/esc_shadow_queue.sv
// Shadow of the host prefetch queue.
// Code fetches enqueue one or two bytes, depending on host width.
// The host queue status pops the head byte or empties the queue.
// Assumes the host never dequeues more bytes than it fetched.
module esc_shadow_queue
    import esc_snoop_pkg::*;
#(
    parameter int DEPTH_WIDE   = 6,
    parameter int DEPTH_NARROW = 4,
    localparam int DMAX = (DEPTH_WIDE > DEPTH_NARROW) ? DEPTH_WIDE : DEPTH_NARROW,
    localparam int CW   = $clog2(DMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wide,
    input  logic          push,
    input  logic [15:0]   push_data,
    input  logic [1:0]    qstat,
    output logic          deq_fire,
    output logic [7:0]    head,
    output logic [CW-1:0] level
);

    logic [7:0]    slot_q [DMAX];
    logic [7:0]    slot_d [DMAX];
    logic [CW-1:0] cnt_q, cnt_d, after_pop;
    logic [CW:0]   need, cap;
    logic          push_ok;

    // Next queue contents: shift on pop, then append fetched bytes.
    always_comb begin
        deq_fire  = ((qstat == QS_FIRST) || (qstat == QS_NEXT)) && (cnt_q != '0);
        after_pop = cnt_q - CW'(deq_fire);
        cap       = host_wide ? (CW+1)'(DEPTH_WIDE) : (CW+1)'(DEPTH_NARROW);
        need      = {1'b0, after_pop} + (host_wide ? (CW+1)'(2) : (CW+1)'(1));
        push_ok   = push && (qstat != QS_FLUSH) && (need <= cap);
        for (int i = 0; i < DMAX; i++) slot_d[i] = slot_q[i];
        if (deq_fire) begin
            for (int i = 0; i < DMAX - 1; i++) slot_d[i] = slot_q[i+1];
            slot_d[DMAX-1] = '0;
        end
        if (push_ok) begin
            for (int i = 0; i < DMAX; i++) begin
                if (CW'(i) == after_pop)
                    slot_d[i] = push_data[7:0];
                else if (host_wide && (CW'(i) == after_pop + 1'b1))
                    slot_d[i] = push_data[15:8];
            end
        end
        if (qstat == QS_FLUSH)
            cnt_d = '0;
        else if (push_ok)
            cnt_d = after_pop + (host_wide ? CW'(2) : CW'(1));
        else
            cnt_d = after_pop;
    end

    // Register the queue slots and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DMAX; i++) slot_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < DMAX; i++) slot_q[i] <= slot_d[i];
        end
    end

    assign head  = slot_q[0];
    assign level = cnt_q;

endmodule

// File: rtl/esc_field_decoder.sv
// Parses dequeued bytes into one coprocessor instruction.
// It checks the escape prefix, takes the addressing byte, then skips
// the displacement bytes. It gives a one-cycle done pulse with the fields.
// Assumes bytes arrive only on a dequeue from the shadow queue.
module esc_field_decoder
    import esc_snoop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] qstat,
    input  logic       deq_fire,
    input  logic [7:0] head,
    output logic       ins_done,
    output ins_t       ins
);

    typedef enum logic [1:0] {D_IDLE, D_ADDR, D_DISP} dstate_e;

    dstate_e    state;
    logic [1:0] disp_left;
    logic [1:0] disp_need;

    // Displacement bytes implied by the mode bits of the head byte.
    always_comb begin
        case (head[7:6])
            2'b01:   disp_need = 2'd1;
            2'b10:   disp_need = 2'd2;
            default: disp_need = 2'd0;
        endcase
    end

    // Byte-by-byte parsing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= D_IDLE;
            disp_left <= '0;
            ins_done  <= 1'b0;
            ins       <= '0;
        end else begin
            ins_done <= 1'b0;
            if (qstat == QS_FLUSH) begin
                state <= D_IDLE;
            end else if (deq_fire && qstat == QS_FIRST) begin
                if (head[7:3] == ESC_PREFIX) begin
                    state      <= D_ADDR;
                    ins.op[5:3] <= head[2:0];
                    ins.len    <= head[2:1];
                end else begin
                    state <= D_IDLE;
                end
            end else if (deq_fire && qstat == QS_NEXT) begin
                case (state)
                    D_ADDR: begin
                        ins.mode    <= head[7:6];
                        ins.op[2:0] <= head[5:3];
                        ins.rm      <= head[2:0];
                        ins.store   <= head[5];
                        if (disp_need == 2'd0) begin
                            ins_done <= 1'b1;
                            state    <= D_IDLE;
                        end else begin
                            disp_left <= disp_need;
                            state     <= D_DISP;
                        end
                    end
                    D_DISP: begin
                        disp_left <= disp_left - 2'd1;
                        if (disp_left == 2'd1) begin
                            ins_done <= 1'b1;
                            state    <= D_IDLE;
                        end
                    end
                    default: state <= D_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/esc_operand_mover.sv
// Publishes decoded instructions. For memory operands it captures the
// address of the host's dummy read, then moves the remaining operand
// beats as bus master. It uses a request/grant handshake and releases
// the bus right after the last beat.
// Assumes the grant is held for as long as the request stays high.
module esc_operand_mover
    import esc_snoop_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wide,
    input  logic          ins_done,
    input  ins_t          ins,
    input  logic          bus_done,
    input  logic          bus_is_code,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_gnt,
    output logic          bus_req,
    output logic          xfer_en,
    output logic          xfer_we,
    output logic [AW-1:0] xfer_addr,
    output logic          dec_valid,
    output ins_t          dec_ins,
    output logic [AW-1:0] dec_addr
);

    typedef enum logic [1:0] {M_IDLE, M_WAIT, M_BUS} mstate_e;

    mstate_e       state;
    logic [3:0]    remain;
    logic [3:0]    beats;
    logic [AW-1:0] step;

    // Beat count and address step for the pending operand.
    always_comb begin
        beats = beat_count(dec_ins.len, host_wide);
        step  = host_wide ? AW'(2) : AW'(1);
    end

    assign bus_req = (state == M_BUS);
    assign xfer_en = bus_req && bus_gnt;

    // Capture, publish and transfer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= M_IDLE;
            remain    <= '0;
            xfer_we   <= 1'b0;
            xfer_addr <= '0;
            dec_valid <= 1'b0;
            dec_ins   <= '0;
            dec_addr  <= '0;
        end else begin
            dec_valid <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (ins_done) begin
                        dec_ins <= ins;
                        if (ins.mode == 2'b11) begin
                            dec_valid <= 1'b1;
                            dec_addr  <= '0;
                        end else begin
                            state <= M_WAIT;
                        end
                    end
                end
                M_WAIT: begin
                    if (bus_done && !bus_is_code) begin
                        dec_valid <= 1'b1;
                        dec_addr  <= bus_addr;
                        xfer_we   <= dec_ins.store;
                        if (dec_ins.store) begin
                            remain    <= beats;
                            xfer_addr <= bus_addr;
                            state     <= M_BUS;
                        end else begin
                            remain    <= beats - 4'd1;
                            xfer_addr <= bus_addr + step;
                            state     <= (beats > 4'd1) ? M_BUS : M_IDLE;
                        end
                    end
                end
                M_BUS: begin
                    if (xfer_en) begin
                        xfer_addr <= xfer_addr + step;
                        remain    <= remain - 4'd1;
                        if (remain == 4'd1) state <= M_IDLE;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/esc_snooper.sv
// Top level of the escape-instruction snooper. It senses the host width
// during reset, mirrors the host prefetch queue, decodes escape
// instructions and handles their memory operands as bus master.
// Assumes qstat is valid in every cycle in step with the host.
module esc_snooper
    import esc_snoop_pkg::*;
#(
    parameter int AW           = 20,
    parameter int DEPTH_WIDE   = 6,
    parameter int DEPTH_NARROW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    qstat,
    input  logic          bus_done,
    input  logic          bus_is_code,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_data,
    input  logic          bus_gnt,
    output logic          host_wide,
    output logic          bus_req,
    output logic          xfer_en,
    output logic          xfer_we,
    output logic [AW-1:0] xfer_addr,
    output logic          dec_valid,
    output logic [5:0]    dec_op,
    output logic [1:0]    dec_mode,
    output logic [2:0]    dec_rm,
    output logic [1:0]    dec_len,
    output logic [AW-1:0] dec_addr
);

    localparam int DMAX = (DEPTH_WIDE > DEPTH_NARROW) ? DEPTH_WIDE : DEPTH_NARROW;
    localparam int LW   = $clog2(DMAX + 1);

    logic          deq_fire;
    logic [7:0]    head;
    logic [LW-1:0] q_level;
    logic          ins_done;
    ins_t          ins;
    ins_t          dec_ins;

    // Width sensing: follow data bit 0 while reset is held, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) host_wide <= bus_data[0];
    end

    esc_shadow_queue #(
        .DEPTH_WIDE  (DEPTH_WIDE),
        .DEPTH_NARROW(DEPTH_NARROW)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wide(host_wide),
        .push     (bus_done && bus_is_code),
        .push_data(bus_data),
        .qstat    (qstat),
        .deq_fire (deq_fire),
        .head     (head),
        .level    (q_level)
    );

    esc_field_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .qstat   (qstat),
        .deq_fire(deq_fire),
        .head    (head),
        .ins_done(ins_done),
        .ins     (ins)
    );

    esc_operand_mover #(.AW(AW)) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wide  (host_wide),
        .ins_done   (ins_done),
        .ins        (ins),
        .bus_done   (bus_done),
        .bus_is_code(bus_is_code),
        .bus_addr   (bus_addr),
        .bus_gnt    (bus_gnt),
        .bus_req    (bus_req),
        .xfer_en    (xfer_en),
        .xfer_we    (xfer_we),
        .xfer_addr  (xfer_addr),
        .dec_valid  (dec_valid),
        .dec_ins    (dec_ins),
        .dec_addr   (dec_addr)
    );

    assign dec_op   = dec_ins.op;
    assign dec_mode = dec_ins.mode;
    assign dec_rm   = dec_ins.rm;
    assign dec_len  = dec_ins.len;

endmodule

// File: rtl/esc_snooper_chk.sv
// Protocol checker for esc_snooper, attached through bind.
// It watches queue occupancy, the bus handshake, decode pulses and
// the sensed width.
module esc_snooper_chk #(
    parameter int DEPTH_WIDE   = 6,
    parameter int DEPTH_NARROW = 4,
    parameter int LW           = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wide,
    input logic [LW-1:0] q_level,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          xfer_en,
    input logic          dec_valid,
    input logic [1:0]    dec_mode
);

    logic armed;

    // Marks cycles that have at least one post-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_level_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (q_level <= (host_wide ? LW'(DEPTH_WIDE) : LW'(DEPTH_NARROW))));

    assert_xfer_granted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |-> (bus_req && bus_gnt));

    assert_release_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(bus_req)) |-> $past(xfer_en));

    assert_reg_no_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_mode == 2'b11) |=> !bus_req);

    assert_dec_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_width_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> $stable(host_wide));

endmodule

bind esc_snooper esc_snooper_chk #(
    .DEPTH_WIDE  (DEPTH_WIDE),
    .DEPTH_NARROW(DEPTH_NARROW),
    .LW          (LW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_wide(host_wide),
    .q_level  (q_level),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .xfer_en  (xfer_en),
    .dec_valid(dec_valid),
    .dec_mode (dec_mode)
);

// File: tb/tb_esc_snooper.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected decodes and transfers,
// and a monitor pops and compares them as the outputs appear.
module tb_esc_snooper;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    qstat = 2'b00;
    logic          bus_done = 1'b0;
    logic          bus_is_code = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_data = '0;
    logic          bus_gnt = 1'b0;
    logic          host_wide, bus_req, xfer_en, xfer_we, dec_valid;
    logic [AW-1:0] xfer_addr, dec_addr;
    logic [5:0]    dec_op;
    logic [1:0]    dec_mode, dec_len;
    logic [2:0]    dec_rm;

    int n_checks = 0;
    int n_fail   = 0;
    int dec_seen = 0;
    int req_cycles = 0;
    bit rel_pending = 1'b0;
    bit done = 1'b0;

    logic [32:0] dq[$];
    string       dtag[$];
    logic [20:0] xq[$];
    string       xtag[$];

    esc_snooper dut (
        .clk(clk), .rst_n(rst_n), .qstat(qstat), .bus_done(bus_done),
        .bus_is_code(bus_is_code), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_gnt(bus_gnt), .host_wide(host_wide), .bus_req(bus_req),
        .xfer_en(xfer_en), .xfer_we(xfer_we), .xfer_addr(xfer_addr),
        .dec_valid(dec_valid), .dec_op(dec_op), .dec_mode(dec_mode),
        .dec_rm(dec_rm), .dec_len(dec_len), .dec_addr(dec_addr)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string msg,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, exp);
        end
    endtask

    // Driver helpers: each drives for one cycle, starting just after a falling edge.
    task automatic fetch(input logic [15:0] d);
        bus_done = 1'b1; bus_is_code = 1'b1; bus_data = d; bus_addr = 20'hFFFF0;
        @(negedge clk);
        bus_done = 1'b0; bus_is_code = 1'b0;
    endtask

    task automatic deq(input logic [1:0] qs);
        qstat = qs;
        @(negedge clk);
        qstat = 2'b00;
    endtask

    task automatic host_read(input logic [AW-1:0] a);
        bus_done = 1'b1; bus_is_code = 1'b0; bus_addr = a; bus_data = 16'hA5A5;
        @(negedge clk);
        bus_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_dec(input logic [5:0] op, input logic [1:0] md, input logic [2:0] rm,
                           input logic [1:0] ln, input logic [AW-1:0] a, input string tag);
        dq.push_back({op, md, rm, ln, a});
        dtag.push_back(tag);
    endtask

    task automatic exp_xfer(input logic we, input logic [AW-1:0] a, input string tag);
        xq.push_back({we, a});
        xtag.push_back(tag);
    endtask

    task automatic do_reset(input logic sense);
        rst_n = 1'b0; bus_data = {15'h0, sense};
        idle(3);
        rst_n = 1'b1; bus_data = 16'h0000;
        idle(1);
    endtask

    // Grant responder: follows the request half a cycle later.
    initial forever begin
        @(negedge clk);
        bus_gnt = bus_req;
    end

    // Monitor: pop and compare as results appear.
    initial forever begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            if (bus_req) req_cycles++;
            if (rel_pending) begin
                check(!bus_req, "R10", "request not released after last beat", 64'(bus_req), 64'd0);
                rel_pending = 1'b0;
            end
            if (dec_valid) begin
                logic [32:0] got;
                got = {dec_op, dec_mode, dec_rm, dec_len, dec_addr};
                dec_seen++;
                if (dq.size() == 0) begin
                    check(1'b0, "R3", "unexpected decode", 64'(got), 64'd0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = dq.pop_front();
                    t = dtag.pop_front();
                    check(got == e, t, "decode fields {op,mode,rm,len,addr}", 64'(got), 64'(e));
                end
            end
            if (xfer_en) begin
                logic [20:0] gx;
                gx = {xfer_we, xfer_addr};
                if (xq.size() == 0) begin
                    check(1'b0, "R8", "unexpected transfer", 64'(gx), 64'd0);
                end else begin
                    logic [20:0] ex;
                    string t;
                    ex = xq.pop_front();
                    t = xtag.pop_front();
                    check(gx == ex && bus_gnt, t, "transfer {we,addr}", 64'(gx), 64'(ex));
                    if (xq.size() == 0) rel_pending = 1'b1;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int r0, d0;
        @(negedge clk);
        // ---- 16-bit host ----
        do_reset(1'b1);
        check(host_wide == 1'b1, "R1", "sensed width (16-bit)", 64'(host_wide), 64'd1);
        check(!dec_valid && !bus_req && !xfer_en, "R10", "idle outputs after reset",
              64'({dec_valid, bus_req, xfer_en}), 64'd0);

        // R4 / R6: register form, no bus request
        exp_dec(6'h08, 2'd3, 3'd3, 2'd0, '0, "R4");
        r0 = req_cycles;
        fetch(16'hC3D9); deq(2'b01); deq(2'b11);
        idle(6);
        check(req_cycles == r0, "R6", "register form raised request", 64'(req_cycles - r0), 64'd0);

        // R7 / R8: load, 8 bytes, code fetch during wait ignored
        exp_dec(6'h20, 2'd0, 3'd6, 2'd2, 20'h01230, "R7");
        exp_xfer(1'b0, 20'h01232, "R8");
        exp_xfer(1'b0, 20'h01234, "R8");
        exp_xfer(1'b0, 20'h01236, "R8");
        fetch(16'h06DC); deq(2'b01); deq(2'b11);
        idle(3);
        fetch(16'h9090);
        host_read(20'h01230);
        idle(15);
        deq(2'b10);
        check(xq.size() == 0, "R8", "load beats left over", 64'(xq.size()), 64'd0);

        // R5 / R9: store with one displacement byte
        exp_dec(6'h14, 2'd1, 3'd1, 2'd1, 20'h00400, "R5");
        exp_xfer(1'b1, 20'h00400, "R9");
        exp_xfer(1'b1, 20'h00402, "R9");
        fetch(16'h61DA); fetch(16'h0012);
        deq(2'b01); deq(2'b11); deq(2'b11);
        idle(3);
        host_read(20'h00400);
        idle(12);
        deq(2'b10);
        check(xq.size() == 0, "R9", "store beats left over", 64'(xq.size()), 64'd0);

        // R5 / R8: two displacement bytes, single-beat load, no request
        exp_dec(6'h00, 2'd2, 3'd5, 2'd0, 20'h00777, "R5");
        r0 = req_cycles;
        fetch(16'h85D8); fetch(16'h3412);
        deq(2'b01); deq(2'b11); deq(2'b11); deq(2'b11);
        idle(3);
        host_read(20'h00777);
        idle(8);
        check(req_cycles == r0, "R8", "single-beat load requested bus", 64'(req_cycles - r0), 64'd0);

        // R3: non-escape first byte is ignored
        d0 = dec_seen;
        fetch(16'hC390); deq(2'b01); deq(2'b11);
        idle(6);
        check(dec_seen == d0, "R3", "non-escape produced decode", 64'(dec_seen - d0), 64'd0);

        // R11: flush mid-decode empties the queue
        exp_dec(6'h18, 2'd3, 3'd1, 2'd1, '0, "R11");
        fetch(16'hC3D9); deq(2'b01); deq(2'b10);
        fetch(16'hC1DB); deq(2'b01); deq(2'b11);
        idle(6);
        check(dq.size() == 0, "R11", "decode after flush missing", 64'(dq.size()), 64'd0);

        // R2 / R12: fill 6 entries, extra fetch dropped, execution order kept
        exp_dec(6'h08, 2'd3, 3'd0, 2'd0, '0, "R2");
        exp_dec(6'h10, 2'd3, 3'd1, 2'd1, '0, "R2");
        exp_dec(6'h18, 2'd3, 3'd2, 2'd1, '0, "R2");
        exp_dec(6'h28, 2'd3, 3'd4, 2'd2, '0, "R12");
        fetch(16'hC0D9); fetch(16'hC1DA); fetch(16'hC2DB); fetch(16'hC7DF);
        idle(3);
        deq(2'b01); deq(2'b11); idle(2);
        deq(2'b01); deq(2'b11); idle(2);
        deq(2'b01); deq(2'b11); idle(2);
        fetch(16'hC4DD); deq(2'b01); deq(2'b11);
        idle(6);
        check(dq.size() == 0, "R12", "wide capacity sequence incomplete", 64'(dq.size()), 64'd0);

        // ---- 8-bit host ----
        do_reset(1'b0);
        check(host_wide == 1'b0, "R1", "sensed width (8-bit)", 64'(host_wide), 64'd0);

        exp_dec(6'h00, 2'd0, 3'd7, 2'd0, 20'h2A000, "R8");
        exp_xfer(1'b0, 20'h2A001, "R8");
        fetch(16'hEED8); fetch(16'hEE07);
        deq(2'b01); deq(2'b11);
        idle(3);
        host_read(20'h2A000);
        idle(10);

        exp_dec(6'h14, 2'd0, 3'd2, 2'd1, 20'h00100, "R9");
        exp_xfer(1'b1, 20'h00100, "R9");
        exp_xfer(1'b1, 20'h00101, "R9");
        exp_xfer(1'b1, 20'h00102, "R9");
        exp_xfer(1'b1, 20'h00103, "R9");
        fetch(16'h00DA); fetch(16'h0022);
        deq(2'b01); deq(2'b11);
        idle(3);
        host_read(20'h00100);
        idle(14);

        exp_dec(6'h08, 2'd3, 3'd0, 2'd0, '0, "R12");
        exp_dec(6'h10, 2'd3, 3'd1, 2'd1, '0, "R12");
        exp_dec(6'h20, 2'd3, 3'd5, 2'd2, '0, "R12");
        fetch(16'h00D9); fetch(16'h00C0); fetch(16'h00DA); fetch(16'h00C1);
        fetch(16'h00DB);
        idle(2);
        deq(2'b01); deq(2'b11); idle(2);
        deq(2'b01); deq(2'b11); idle(2);
        fetch(16'h00DC); fetch(16'h00C5);
        deq(2'b01); deq(2'b11);
        idle(10);

        check(dq.size() == 0, "R7", "expected decodes never seen", 64'(dq.size()), 64'd0);
        check(xq.size() == 0, "R10", "expected transfers never seen", 64'(xq.size()), 64'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule